// File: doc/BRIEF.md
# Hysteretic Voltage Window Monitor

This block watches a supply rail through an unsigned code from an external converter. It decides whether the rail sits inside an allowed window. The window has a lower (undervoltage) edge and an upper (overvoltage) edge. Each edge has its own pair of thresholds: an upper "rising" code and a lower "falling" code. Because of this, a value that hovers around one edge does not make the result chatter.

The block produces a `fault` output and its complement `compliant`, and a power-up sequencer downstream consumes `compliant`. A value that leaves the window raises `fault` at once. A value that re-enters the window clears `fault` only after it has stayed inside for an uninterrupted, programmable number of samples. A single stray sample outside the window restarts that wait.

The four threshold codes and the qualification length are configuration inputs. They are latched once, as monitoring starts after reset. The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer before monitoring begins.

Top module: `win_monitor`

## Requirements
- R1: While `rst_n` is low, and for the first three rising clock edges after it goes high, `fault` is 1 and `compliant` is 0. The first sample compared against the thresholds is the one present at the fourth rising edge after release.
- R2: The lower-edge state becomes "above" when `sample >= uv_rise`. It becomes "below" when `sample < uv_fall`. For codes between the two it keeps its previous value. It starts out "below".
- R3: The upper-edge state becomes "over" when `sample >= ov_rise`. It becomes "not over" when `sample < ov_fall`. For codes between the two it keeps its previous value. It starts out "not over".
- R4: A sample counts as in-window only when the lower-edge state is "above" and the upper-edge state is "not over", both taken after that sample has been applied.
- R5: An out-of-window sample sets `fault` to 1 at the same clock edge that samples it, so `fault` is visible one cycle after the sample is presented.
- R6: While `fault` is 1, `fault` clears at the edge that samples the Q-th consecutive in-window sample. Q is the latched `qual_len`, and a `qual_len` of 0 behaves as 1.
- R7: Any out-of-window sample restarts the consecutive count, so a short excursion delays the release of `fault` by a full Q samples.
- R8: `compliant` is always the inverse of `fault`.
- R9: The four thresholds and `qual_len` are captured at the third rising edge after reset release. Changes on those inputs afterwards have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally on release |
| sample | input | DATA_W | Monitored rail code, one sample per clock |
| uv_rise | input | DATA_W | Lower edge: code at or above which the rail is "above" |
| uv_fall | input | DATA_W | Lower edge: code below which the rail is "below" |
| ov_rise | input | DATA_W | Upper edge: code at or above which the rail is "over" |
| ov_fall | input | DATA_W | Upper edge: code below which the rail is "not over" |
| qual_len | input | QUAL_W | Consecutive in-window samples required to clear fault (0 acts as 1) |
| fault | output | 1 | 1 while the rail is out of window or not yet qualified |
| compliant | output | 1 | Inverse of fault; go signal for the sequencer |

## Verification
Every sample is presented on a falling edge and captured by the next rising edge. Both the fast trip and the qualified release land at that same rising edge, so the bench compares `fault` and `compliant` on the following falling edge, one cycle after each stimulus. After reset release the bench checks that `fault` stays held for exactly three edges before it supplies the first evaluated sample. The bench's reference model tracks both hysteresis states and the consecutive count, and it advances once for every sample driven. The release can therefore be predicted exactly, whether Q is 0, 1, 5 or 20, and including dips that restart the count.

// File: rtl/win_monitor_pkg.sv
`timescale 1ns/1ps
package win_monitor_pkg;
  localparam int NUM_EDGES = 2;
  localparam int UV_IDX    = 0;
  localparam int OV_IDX    = 1;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/wm_rst_sync.sv
`timescale 1ns/1ps
module wm_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[DEPTH-1];
endmodule

// File: rtl/wm_hyst_cmp.sv
`timescale 1ns/1ps
module wm_hyst_cmp #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] rise,
  input  logic [DATA_W-1:0] fall,
  output logic              state_d,
  output logic              state_q
);
  always_comb begin
    state_d = state_q;
    if (en) begin
      if (sample >= rise)     state_d = 1'b1;
      else if (sample < fall) state_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= 1'b0;
    else         state_q <= state_d;
  end

  // R2 / R3: state only rises on a sample at or above the rising code
  assert_rise_on_upper_code_R2: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(state_q) |-> $past(en && (sample >= rise)));
  // R2 / R3: state only falls on a sample below the falling code
  assert_fall_on_lower_code_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(state_q) |-> $past(en && (sample < fall)));
endmodule

// File: rtl/wm_qual_timer.sv
`timescale 1ns/1ps
module wm_qual_timer #(
  parameter int QUAL_W = 16
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              en,
  input  logic              win_i,
  input  logic [QUAL_W-1:0] qual_len,
  output logic              fault_q
);
  localparam int EXT_W = QUAL_W + 1;

  logic [QUAL_W-1:0] cnt_q, cnt_d;
  logic              fault_d;
  logic [EXT_W-1:0]  len_eff;
  logic [EXT_W-1:0]  cnt_inc;

  always_comb begin
    len_eff = (qual_len == '0) ? EXT_W'(1) : {1'b0, qual_len};
    cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
    fault_d = fault_q;
    cnt_d   = cnt_q;
    if (!en || !win_i) begin
      fault_d = 1'b1;
      cnt_d   = '0;
    end else if (fault_q) begin
      if (cnt_inc >= len_eff) begin
        fault_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_inc[QUAL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fault_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      fault_q <= fault_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_fast_trip_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (en && !win_i) |=> fault_q);
  assert_release_needs_window_R6: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(fault_q) |-> $past(en && win_i));
  assert_count_below_len_R7: assert property (@(posedge clk) disable iff (!srst_n)
    {1'b0, cnt_q} < len_eff);
  assert_held_until_armed_R1: assert property (@(posedge clk) disable iff (!srst_n)
    !en |=> fault_q);
endmodule

// File: rtl/win_monitor.sv
`timescale 1ns/1ps
module win_monitor
  import win_monitor_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int QUAL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] uv_rise,
  input  logic [DATA_W-1:0] uv_fall,
  input  logic [DATA_W-1:0] ov_rise,
  input  logic [DATA_W-1:0] ov_fall,
  input  logic [QUAL_W-1:0] qual_len,
  output logic              fault,
  output logic              compliant
);
  logic srst_n;
  logic armed_q, armed_d;
  logic [NUM_EDGES-1:0][DATA_W-1:0] rise_q, rise_d, fall_q, fall_d;
  logic [QUAL_W-1:0] qlen_q, qlen_d;
  logic [NUM_EDGES-1:0] st_d, st_q;
  logic win_d;
  logic fault_q;

  wm_rst_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // Configuration capture: loaded on the single cycle before arming (R9)
  always_comb begin
    armed_d = 1'b1;
    rise_d  = rise_q;
    fall_d  = fall_q;
    qlen_d  = qlen_q;
    if (!armed_q) begin
      rise_d[UV_IDX] = uv_rise;
      fall_d[UV_IDX] = uv_fall;
      rise_d[OV_IDX] = ov_rise;
      fall_d[OV_IDX] = ov_fall;
      qlen_d         = qual_len;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      armed_q <= 1'b0;
      rise_q  <= '0;
      fall_q  <= '0;
      qlen_q  <= '0;
    end else begin
      armed_q <= armed_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      qlen_q  <= qlen_d;
    end
  end

  for (genvar g = 0; g < NUM_EDGES; g++) begin : g_edge
    wm_hyst_cmp #(.DATA_W(DATA_W)) u_cmp (
      .clk(clk), .srst_n(srst_n), .en(armed_q), .sample(sample),
      .rise(rise_q[g]), .fall(fall_q[g]),
      .state_d(st_d[g]), .state_q(st_q[g]));
  end

  // R4: window from post-update edge states
  assign win_d = st_d[UV_IDX] & ~st_d[OV_IDX];

  wm_qual_timer #(.QUAL_W(QUAL_W)) u_qual (
    .clk(clk), .srst_n(srst_n), .en(armed_q), .win_i(win_d),
    .qual_len(qlen_q), .fault_q(fault_q));

  assign fault     = fault_q;
  assign compliant = ~fault_q;

  // R4: a cleared fault implies the edge states agree on in-window
  assert_clear_means_window_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !fault_q |-> (st_q[UV_IDX] && !st_q[OV_IDX]));
endmodule

// File: tb/win_monitor_test.sv
`timescale 1ns/1ps
module win_monitor_test;
  localparam int DW = 12;
  localparam int QW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [DW-1:0] uv_rise = '0, uv_fall = '0, ov_rise = '0, ov_fall = '0;
  logic [QW-1:0] qual_len = '0;
  logic fault, compliant;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_ur, m_uf, m_or, m_of, m_q, m_cnt;
  bit m_uv, m_ov, m_fault;

  always #2 clk = ~clk;

  win_monitor #(.DATA_W(DW), .QUAL_W(QW)) uut (
    .clk(clk), .rst_n(rst_n), .sample(sample),
    .uv_rise(uv_rise), .uv_fall(uv_fall), .ov_rise(ov_rise), .ov_fall(ov_fall),
    .qual_len(qual_len), .fault(fault), .compliant(compliant));

  function automatic bit in_window(bit uv, bit ov);
    return uv && !ov;
  endfunction

  task automatic check(string req, bit exp_fault);
    checks++;
    if (fault !== exp_fault || compliant !== !exp_fault) begin
      errors++;
      $display("FAIL %s: fault=%b compliant=%b expected fault=%b compliant=%b",
               req, fault, compliant, exp_fault, !exp_fault);
    end
  endtask

  task automatic model_step(int v);
    if (v >= m_ur) m_uv = 1; else if (v < m_uf) m_uv = 0;
    if (v >= m_or) m_ov = 1; else if (v < m_of) m_ov = 0;
    if (!in_window(m_uv, m_ov)) begin
      m_fault = 1; m_cnt = 0;
    end else if (m_fault) begin
      if (m_cnt + 1 >= m_q) begin m_fault = 0; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  task automatic drive(int v, string req);
    sample = DW'(v);
    model_step(v);
    @(negedge clk);
    check(req, m_fault);
  endtask

  task automatic do_reset(int q);
    @(negedge clk);
    rst_n = 0;
    uv_fall = 100; uv_rise = 110; ov_fall = 200; ov_rise = 210;
    qual_len = QW'(q);
    m_uf = 100; m_ur = 110; m_of = 200; m_or = 210;
    m_q = (q == 0) ? 1 : q;
    m_uv = 0; m_ov = 0; m_fault = 1; m_cnt = 0;
    sample = 150;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b1);
    rst_n = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 before armed", 1'b1);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // Directed hysteresis with Q=1
    do_reset(1);
    drive(105, "R2 between uv codes stays below");
    drive(110, "R2 uv_rise reached, R6 Q=1 release");
    drive(105, "R2 hold above in band");
    drive(99,  "R5 uv_fall crossed trips");
    drive(105, "R2 band after fall stays below");
    drive(205, "R3 below ov_rise, in window");
    drive(210, "R3 ov_rise reached trips");
    drive(205, "R3 hold over in band");
    drive(199, "R3 ov_fall crossed clears, R8");
    // R9: configuration changes after arming are ignored
    uv_rise = 12'hFFF; uv_fall = 12'hFF0; ov_rise = 12'd1; ov_fall = 12'd0; qual_len = 16'd900;
    drive(150, "R9 late threshold change ignored");
    drive(300, "R9 old ov_rise still used");
    drive(150, "R9 old qual length still used");

    // Q=0 behaves as 1
    do_reset(0);
    drive(150, "R6 qual_len 0 acts as 1");

    // Restart on dip, Q=5
    do_reset(5);
    for (int i = 0; i < 4; i++) drive(150, "R6 counting");
    drive(95, "R7 dip restarts count");
    for (int i = 0; i < 4; i++) drive(150, "R7 wait restarted");
    drive(150, "R6 fifth consecutive clears");
    drive(250, "R5 over trips next cycle");

    // Constrained random, Q=20
    do_reset(20);
    for (int i = 0; i < 4000; i++) begin
      int v;
      if ($urandom_range(15) == 0) v = $urandom_range(300);
      else if ($urandom_range(3) == 0) v = $urandom_range(215, 95);
      else v = $urandom_range(190, 120);
      drive(v, "R4 random window");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule